// File: doc/BRIEF.md
# Application-Aware Row-Hit-First Request Scheduler

This block sits in front of one memory channel and holds up to sixteen pending memory requests. Each request names a target bank, a row within that bank and the application that produced it. Every cycle the scheduler looks at all held requests whose bank is idle and issues at most one of them. It may serve them in any order, not only the order in which they arrived.

The choice follows a fixed ranking. Requests from applications that an outside monitor has flagged as very light memory users (fewer than one miss per thousand instructions) come first. After those come requests that hit the row currently open in their bank. Requests that miss the open row come last. Within one class, the request that has been waiting longest wins. The block records the last row issued to each bank and uses it as that bank's open row. It does not compute the per-application flags and it does not model DRAM timing: both arrive as inputs.

Top module: `app_aware_req_sched`

## Requirements
- R1: After reset the buffer is empty, `req_ready` is 1, `iss_valid` is 0, and every bank has no open row, so the first issue to any bank reports `iss_hit` = 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 exactly when sixteen requests are held. A request offered while the buffer is full is not stored, and `req_ready` returns to 1 after the next issue.
- R3: Only requests whose bank has its bit set in `bank_idle` (bit n for bank n) can be issued. `iss_valid` is 1 in every cycle in which at least one held request targets an idle bank, and 0 in every other cycle.
- R4: Among eligible requests of the same flag class, a row hit is issued before a row miss. A row hit means the request row equals the last row issued to that bank since reset.
- R5: Among eligible requests with the same flag class and the same hit status, the one accepted earliest is issued.
- R6: An eligible request whose application has its bit set in `low_int_flags` (bit a for application a) is issued before any unflagged request, even an older one or a row hit.
- R7: Within the flagged class, row hits come before row misses, and the earliest accepted request wins among equals.
- R8: Every issue sets the open row of the issued bank to the issued row. `iss_hit` reports whether the issued request matched the open row that was in place before the issue.
- R9: A request accepted on one edge can be issued from the following cycle onward. An issue shown on `iss_*` is consumed on the next rising edge and needs no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New request offered |
| req_ready | output | 1 | Buffer has room |
| req_bank | input | BANK_W | Target bank of the offered request |
| req_row | input | ROW_W | Target row of the offered request |
| req_app | input | APP_W | Application of the offered request |
| low_int_flags | input | 2**APP_W | Per-application very-light-traffic flag |
| bank_idle | input | BANKS | Per-bank ready-for-command flag |
| iss_valid | output | 1 | A request is issued this cycle |
| iss_bank | output | BANK_W | Bank of the issued request |
| iss_row | output | ROW_W | Row of the issued request |
| iss_app | output | APP_W | Application of the issued request |
| iss_hit | output | 1 | Issued request hit its bank's open row |

## Verification
The issue outputs are combinational from the stored entries, the open-row table and the current `bank_idle` and `low_int_flags` values. An accepted request therefore shows on `iss_*` in the cycle after the edge that stored it, and is removed on the edge that follows the cycle in which it is shown. The bench drives inputs on falling edges and samples one time unit later. It first checks that a new request is absent in the cycle it is offered. It then checks that the request is present one edge later and gone after the following edge. For ordering tests it keeps all banks busy while loading, then enables banks for exactly one cycle per expected issue, so each sample sees a single known ranking decision.

// File: rtl/sched_pkg.sv
// Package: shared types for the application-aware request scheduler.
// Assumes: the priority class is the two-bit concatenation {flagged, row-hit},
// so a larger class value always means a higher priority.
package sched_pkg;

    typedef enum logic [1:0] {
        CLS_MISS     = 2'd0,
        CLS_HIT      = 2'd1,
        CLS_URG_MISS = 2'd2,
        CLS_URG_HIT  = 2'd3
    } prio_cls_e;

    // Build a request's priority class from its flag and row-hit status.
    function automatic prio_cls_e make_cls(input logic urgent, input logic hit);
        return prio_cls_e'({urgent, hit});
    endfunction

endpackage

// File: rtl/req_buffer.sv
// Module: req_buffer
// Holds pending requests in DEPTH slots. Each valid slot carries a relative age:
// the number of valid entries accepted after it. The oldest entry has the
// largest age, and ages are always distinct.
// Assumes: enq_i is only raised when full_o is 0; deq_idx_i names a valid slot.
module req_buffer #(
    parameter int DEPTH  = 16,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    parameter int APP_W  = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int AGE_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_i,
    input  logic [BANK_W-1:0] enq_bank_i,
    input  logic [ROW_W-1:0]  enq_row_i,
    input  logic [APP_W-1:0]  enq_app_i,
    input  logic              deq_i,
    input  logic [IDX_W-1:0]  deq_idx_i,
    output logic [DEPTH-1:0]  vld_o,
    output logic [BANK_W-1:0] bank_o [DEPTH],
    output logic [ROW_W-1:0]  row_o  [DEPTH],
    output logic [APP_W-1:0]  app_o  [DEPTH],
    output logic [AGE_W-1:0]  age_o  [DEPTH],
    output logic              full_o
);

    logic [DEPTH-1:0]  vld_q;
    logic [BANK_W-1:0] bank_q [DEPTH];
    logic [ROW_W-1:0]  row_q  [DEPTH];
    logic [APP_W-1:0]  app_q  [DEPTH];
    logic [AGE_W-1:0]  age_q  [DEPTH];
    logic [IDX_W-1:0]  free_idx;
    logic [AGE_W-1:0]  deq_age;

    // Find the lowest-numbered empty slot for the next accepted request.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IDX_W'(i);
        end
    end

    // Age of the entry leaving this cycle, used to close the gap it leaves.
    assign deq_age = age_q[deq_idx_i];

    // Store new entries, retire issued ones, and keep relative ages dense.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                bank_q[i] <= '0;
                row_q[i]  <= '0;
                app_q[i]  <= '0;
                age_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (enq_i && free_idx == IDX_W'(i)) begin
                    vld_q[i]  <= 1'b1;
                    bank_q[i] <= enq_bank_i;
                    row_q[i]  <= enq_row_i;
                    app_q[i]  <= enq_app_i;
                    age_q[i]  <= '0;
                end else if (deq_i && deq_idx_i == IDX_W'(i)) begin
                    vld_q[i] <= 1'b0;
                end else if (vld_q[i]) begin
                    age_q[i] <= age_q[i] + AGE_W'(enq_i)
                              - AGE_W'(deq_i && (age_q[i] > deq_age));
                end
            end
        end
    end

    assign vld_o  = vld_q;
    assign bank_o = bank_q;
    assign row_o  = row_q;
    assign app_o  = app_q;
    assign age_o  = age_q;
    assign full_o = &vld_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_i && !deq_i) |=> $stable(vld_q)); // R2
    AST_DEQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        deq_i |-> vld_q[deq_idx_i]); // R9
    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(full_o) && !$past(deq_i) |-> full_o); // R2

endmodule

// File: rtl/bank_row_table.sv
// Module: bank_row_table
// Records per bank the last row issued to it, which is taken as the open row.
// Assumes: at most one update per cycle; a bank with no issue since reset
// has no open row.
module bank_row_table #(
    parameter int BANKS = 4,
    parameter int ROW_W = 8,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [BANK_W-1:0] upd_bank_i,
    input  logic [ROW_W-1:0]  upd_row_i,
    output logic [BANKS-1:0]  open_vld_o,
    output logic [ROW_W-1:0]  open_row_o [BANKS]
);

    logic [BANKS-1:0] vld_q;
    logic [ROW_W-1:0] row_q [BANKS];

    // Open the issued row in the issued bank; clear all banks on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int b = 0; b < BANKS; b++) row_q[b] <= '0;
        end else if (upd_i) begin
            vld_q[upd_bank_i] <= 1'b1;
            row_q[upd_bank_i] <= upd_row_i;
        end
    end

    assign open_vld_o = vld_q;
    assign open_row_o = row_q;

    AST_ROW_OPENED: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> open_vld_o[$past(upd_bank_i)]
                  && (open_row_o[$past(upd_bank_i)] == $past(upd_row_i))); // R8

endmodule

// File: rtl/sched_picker.sv
// Module: sched_picker
// Ranks every held request whose bank is idle by {class, age} and selects the
// maximum. Ages are distinct, so exactly one winner exists when any is eligible.
// Assumes: BANKS is a power of two, so every bank field indexes a real bank.
module sched_picker
    import sched_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BANKS = 4,
    parameter int ROW_W = 8,
    parameter int APP_W = 2,
    localparam int BANK_W = $clog2(BANKS),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int AGE_W  = $clog2(DEPTH),
    localparam int NAPPS  = 1 << APP_W,
    localparam int KEY_W  = AGE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEPTH-1:0]  vld_i,
    input  logic [BANK_W-1:0] bank_i [DEPTH],
    input  logic [ROW_W-1:0]  row_i  [DEPTH],
    input  logic [APP_W-1:0]  app_i  [DEPTH],
    input  logic [AGE_W-1:0]  age_i  [DEPTH],
    input  logic [BANKS-1:0]  open_vld_i,
    input  logic [ROW_W-1:0]  open_row_i [BANKS],
    input  logic [BANKS-1:0]  bank_idle_i,
    input  logic [NAPPS-1:0]  low_int_i,
    output logic              sel_vld_o,
    output logic [IDX_W-1:0]  sel_idx_o,
    output logic              sel_hit_o
);

    logic [DEPTH-1:0] elig;
    logic [DEPTH-1:0] hit;
    logic [DEPTH-1:0] urg;
    logic [KEY_W-1:0] key [DEPTH];

    // Classify each entry: eligibility, row hit, flagged application, sort key.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            elig[i] = vld_i[i] && bank_idle_i[bank_i[i]];
            hit[i]  = open_vld_i[bank_i[i]] && (open_row_i[bank_i[i]] == row_i[i]);
            urg[i]  = low_int_i[app_i[i]];
            key[i]  = {make_cls(urg[i], hit[i]), age_i[i]};
        end
    end

    // Pick the eligible entry with the largest key.
    always_comb begin
        logic [KEY_W-1:0] best;
        best      = '0;
        sel_vld_o = 1'b0;
        sel_idx_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && (!sel_vld_o || key[i] > best)) begin
                sel_vld_o = 1'b1;
                sel_idx_o = IDX_W'(i);
                best      = key[i];
            end
        end
        sel_hit_o = hit[sel_idx_o];
    end

    AST_URGENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld_o && |(elig & urg)) |-> low_int_i[app_i[sel_idx_o]]); // R6
    AST_HIT_BEATS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld_o && !(|(elig & urg)) && |(elig & hit)) |-> sel_hit_o); // R4

endmodule

// File: rtl/app_aware_req_sched.sv
// Module: app_aware_req_sched (top)
// Request buffer, open-row table and ranking logic for one channel. Issues at
// most one request per cycle to an idle bank, ranked flagged-first, then
// row-hit-first, then oldest-first.
// Assumes: the consumer always takes an issued request in the cycle it is
// shown; bank_idle and low_int_flags are produced elsewhere.
module app_aware_req_sched #(
    parameter int DEPTH = 16,
    parameter int BANKS = 4,
    parameter int ROW_W = 8,
    parameter int APP_W = 2,
    localparam int BANK_W = $clog2(BANKS),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int AGE_W  = $clog2(DEPTH),
    localparam int NAPPS  = 1 << APP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [APP_W-1:0]  req_app,
    input  logic [NAPPS-1:0]  low_int_flags,
    input  logic [BANKS-1:0]  bank_idle,
    output logic              iss_valid,
    output logic [BANK_W-1:0] iss_bank,
    output logic [ROW_W-1:0]  iss_row,
    output logic [APP_W-1:0]  iss_app,
    output logic              iss_hit
);

    logic              enq;
    logic              full;
    logic [DEPTH-1:0]  e_vld;
    logic [BANK_W-1:0] e_bank [DEPTH];
    logic [ROW_W-1:0]  e_row  [DEPTH];
    logic [APP_W-1:0]  e_app  [DEPTH];
    logic [AGE_W-1:0]  e_age  [DEPTH];
    logic [BANKS-1:0]  open_vld;
    logic [ROW_W-1:0]  open_row [BANKS];
    logic              sel_vld;
    logic [IDX_W-1:0]  sel_idx;
    logic              sel_hit;

    // Accept a request whenever the buffer has a free slot.
    assign req_ready = !full;
    assign enq       = req_valid && req_ready;

    req_buffer #(
        .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .APP_W(APP_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .enq_i(enq), .enq_bank_i(req_bank), .enq_row_i(req_row), .enq_app_i(req_app),
        .deq_i(sel_vld), .deq_idx_i(sel_idx),
        .vld_o(e_vld), .bank_o(e_bank), .row_o(e_row), .app_o(e_app), .age_o(e_age),
        .full_o(full)
    );

    bank_row_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .upd_i(sel_vld), .upd_bank_i(e_bank[sel_idx]), .upd_row_i(e_row[sel_idx]),
        .open_vld_o(open_vld), .open_row_o(open_row)
    );

    sched_picker #(
        .DEPTH(DEPTH), .BANKS(BANKS), .ROW_W(ROW_W), .APP_W(APP_W)
    ) u_pick (
        .clk(clk), .rst_n(rst_n),
        .vld_i(e_vld), .bank_i(e_bank), .row_i(e_row), .app_i(e_app), .age_i(e_age),
        .open_vld_i(open_vld), .open_row_i(open_row),
        .bank_idle_i(bank_idle), .low_int_i(low_int_flags),
        .sel_vld_o(sel_vld), .sel_idx_o(sel_idx), .sel_hit_o(sel_hit)
    );

    // Present the chosen entry on the issue port.
    assign iss_valid = sel_vld;
    assign iss_bank  = e_bank[sel_idx];
    assign iss_row   = e_row[sel_idx];
    assign iss_app   = e_app[sel_idx];
    assign iss_hit   = sel_hit;

    AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> bank_idle[iss_bank]); // R3
    AST_READY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !enq) |=> req_ready); // R2

endmodule

// File: tb/app_aware_req_sched_tb_top.sv
module app_aware_req_sched_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // Table: bank, row, app, expected hit; issued one at a time with all banks idle.
    localparam int V_BANK [NV] = '{0, 0, 1, 0, 0, 1, 3, 3};
    localparam int V_ROW  [NV] = '{5, 5, 5, 6, 6, 5, 255, 255};
    localparam int V_APP  [NV] = '{0, 1, 2, 3, 0, 1, 2, 2};
    localparam int V_HIT  [NV] = '{0, 1, 0, 0, 1, 1, 0, 1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_bank = '0;
    logic [7:0] req_row = '0;
    logic [1:0] req_app = '0;
    logic [3:0] low_int_flags = '0;
    logic [3:0] bank_idle = '0;
    logic       iss_valid;
    logic [1:0] iss_bank;
    logic [7:0] iss_row;
    logic [1:0] iss_app;
    logic       iss_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    app_aware_req_sched dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_app(req_app),
        .low_int_flags(low_int_flags), .bank_idle(bank_idle),
        .iss_valid(iss_valid), .iss_bank(iss_bank), .iss_row(iss_row),
        .iss_app(iss_app), .iss_hit(iss_hit)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Offer one request for exactly one rising edge.
    task automatic push(input int b, input int r, input int a);
        @(negedge clk);
        req_valid = 1'b1;
        req_bank  = 2'(b);
        req_row   = 8'(r);
        req_app   = 2'(a);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Open the banks in mask for one cycle and check the single issue shown.
    task automatic expect_issue(input string req, input logic [3:0] mask,
                                input int b, input int r, input int a, input int h);
        @(negedge clk);
        bank_idle = mask;
        #1;
        check(req, "iss_valid", 32'(iss_valid), 1);
        check(req, "iss_bank", 32'(iss_bank), 32'(b));
        check(req, "iss_row", 32'(iss_row), 32'(r));
        check(req, "iss_app", 32'(iss_app), 32'(a));
        check(req, "iss_hit", 32'(iss_hit), 32'(h));
        @(posedge clk);
        #1;
        bank_idle = 4'h0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n_iss;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state with all banks idle and nothing held.
        bank_idle = 4'hF;
        @(negedge clk);
        #1;
        check("R1", "req_ready", 32'(req_ready), 1);
        check("R1", "iss_valid", 32'(iss_valid), 0);

        // Table walk: R9 timing, R8 open-row tracking, R1 first-touch miss.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_bank  = 2'(V_BANK[k]);
            req_row   = 8'(V_ROW[k]);
            req_app   = 2'(V_APP[k]);
            #1;
            check("R9", "iss_valid before store", 32'(iss_valid), 0);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            check("R9", "iss_valid after store", 32'(iss_valid), 1);
            check("R8", "iss_bank", 32'(iss_bank), 32'(V_BANK[k]));
            check("R8", "iss_row", 32'(iss_row), 32'(V_ROW[k]));
            check("R8", "iss_app", 32'(iss_app), 32'(V_APP[k]));
            check(k == 0 ? "R1" : "R8", "iss_hit", 32'(iss_hit), 32'(V_HIT[k]));
            @(negedge clk);
            #1;
            check("R9", "iss_valid after issue", 32'(iss_valid), 0);
        end
        bank_idle = 4'h0;

        // R4/R5: open row 3 in bank 0, then a miss and two hits.
        push(0, 3, 0);
        expect_issue("R4", 4'hF, 0, 3, 0, 0);
        push(0, 7, 1);
        push(0, 3, 1);
        push(0, 3, 2);
        expect_issue("R4", 4'hF, 0, 3, 1, 1);
        expect_issue("R5", 4'hF, 0, 3, 2, 1);
        expect_issue("R4", 4'hF, 0, 7, 1, 0);

        // R6/R7: application 3 flagged, bank 0 open at row 7.
        low_int_flags = 4'b1000;
        push(0, 9, 0);
        push(0, 9, 3);
        push(0, 2, 3);
        push(0, 7, 3);
        expect_issue("R7", 4'hF, 0, 7, 3, 1);
        expect_issue("R7", 4'hF, 0, 9, 3, 0);
        expect_issue("R6", 4'hF, 0, 2, 3, 0);
        expect_issue("R6", 4'hF, 0, 9, 0, 0);
        low_int_flags = 4'b0000;

        // R3: older request on a busy bank waits; none issues when its bank is busy.
        push(0, 1, 0);
        push(1, 1, 0);
        expect_issue("R3", 4'b0010, 1, 1, 0, 0);
        @(negedge clk);
        bank_idle = 4'b1110;
        #1;
        check("R3", "iss_valid busy bank", 32'(iss_valid), 0);
        expect_issue("R3", 4'b0001, 0, 1, 0, 0);

        // R2: fill sixteen entries, offer one more while full, then drain.
        for (int k = 0; k < 16; k++) begin
            #1;
            check("R2", "req_ready while filling", 32'(req_ready), 1);
            push(k % 4, k + 16, 0);
        end
        #1;
        check("R2", "req_ready when full", 32'(req_ready), 0);
        push(3, 200, 0);
        n_iss = 0;
        bank_idle = 4'hF;
        for (int c = 0; c < 20; c++) begin
            #1;
            if (iss_valid) n_iss++;
            if (c == 0) check("R5", "first drained row", 32'(iss_row), 16);
            if (c == 1) check("R2", "req_ready after issue", 32'(req_ready), 1);
            @(negedge clk);
        end
        check("R2", "entries drained", 32'(n_iss), 16);
        bank_idle = 4'h0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule